// File: doc/BRIEF.md
# Non-maskable interrupt edge detector

This block watches one asynchronous interrupt pin that cannot be masked. It decides when the CPU may take that interrupt. The pin passes through a two-stage synchronizer. A polarity bit picks whether a rising or a falling transition counts as an event. When software flips that polarity bit, a blanking counter starts, and events that arrive during the window are discarded. A detected event is held as pending until the CPU acknowledges it.

A pending event is shown to the CPU only when the CPU is not blocking exceptions. Two conditions lift the block: the CPU is asleep, or software has set a force-accept bit. The request always carries priority level 16, the top of the scale, where 1 is the lowest level. When software enables mask loading, the acknowledge of a request also writes 15 into the CPU interrupt mask.

The core is a three-state machine:
- `NS_IDLE`: nothing is pending.
- `NS_HELD`: an event is pending but acceptance is blocked.
- `NS_PRESENT`: the request is driven.

The transitions are:
- IDLE→PRESENT: an event arrives while acceptance is open.
- IDLE→HELD: an event arrives while acceptance is closed.
- HELD→PRESENT: acceptance opens.
- PRESENT→HELD: acceptance closes before the acknowledge.
- PRESENT→IDLE: an acknowledge arrives without a new event.
- PRESENT→PRESENT or PRESENT→HELD: a new event arrives together with an acknowledge, so the request stays pending.

Top module: `nmi_accept_unit`

## Requirements
- R1: `nmi_level` is always 5'd16, the highest priority on a scale of 1 (lowest) to 16.
- R2: After reset, `nmi_req` and `mask_we` are 0, rising-edge detection is selected, force-accept is off and mask loading is off.
- R3: With configuration bit 0 = 1 (rising), a low-to-high pin change driven in cycle N raises `nmi_req` in cycle N+3. A high-to-low change raises nothing.
- R4: With configuration bit 0 = 0 (falling), a high-to-low pin change raises `nmi_req` three cycles later. A low-to-high change raises nothing.
- R5: A configuration write in cycle N that changes bit 0 blanks detection for six cycles. Pin changes driven in cycles N-1 to N+4 are dropped for good. A change in cycle N+5 is detected.
- R6: A configuration write that leaves bit 0 unchanged does not start blanking.
- R7: With `cpu_block`=1, `cpu_sleep`=0 and force off, a detected event is held with `nmi_req`=0. The request is raised in the cycle after `cpu_block` falls.
- R8: With `cpu_sleep`=1, the request is raised regardless of `cpu_block`.
- R9: With configuration bit 1 (force accept) = 1, the request is raised even when `cpu_block`=1 and `cpu_sleep`=0.
- R10: An `nmi_ack` while `nmi_req`=1 clears the request from the next cycle. In that same cycle, `mask_we` pulses with `mask_val`=15 if configuration bit 2 (mask load) = 1. Otherwise `mask_we` stays 0.
- R11: An `nmi_ack` while `nmi_req`=0 has no effect: `mask_we` stays 0 and no request appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| nmi_pin | input | 1 | Asynchronous interrupt pin |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 3 | Bit 0 = rising polarity, bit 1 = force accept, bit 2 = mask load |
| cpu_block | input | 1 | CPU exception block flag |
| cpu_sleep | input | 1 | CPU sleep flag |
| nmi_ack | input | 1 | CPU acknowledge of the request |
| nmi_req | output | 1 | Interrupt request to the CPU |
| nmi_level | output | 5 | Priority level of the request |
| mask_we | output | 1 | Load strobe for the CPU interrupt mask |
| mask_val | output | 4 | Value to load into the mask |

## Verification
The block's results fall due at different times after a stimulus driven in cycle N:
- A pin change shows on `nmi_req` in cycle N+3: two synchronizer stages, then the state register.
- An acknowledge shows on `mask_we` in cycle N and clears `nmi_req` in N+1.
- A release of `cpu_block` raises the request in cycle N+1.
- A polarity write blanks pin changes made from N-1 through N+4.

The bench's driver enqueues each expected value tagged with the exact cycle it falls due. A monitor compares each item at the falling clock edge of that cycle. Both the last dropped cycle and the first detected cycle of the blanking window are placed deliberately.

// File: rtl/nmi_pkg.sv
package nmi_pkg;
    localparam int NMI_LEVEL_W = 5;
    localparam int NMI_LEVEL   = 16;
    localparam int MASK_W      = 4;
    localparam int MASK_LOAD   = 15;
    localparam int CFG_W       = 3;
    localparam int CFG_RISE    = 0;
    localparam int CFG_FORCE   = 1;
    localparam int CFG_MLOAD   = 2;

    typedef enum logic [1:0] {
        NS_IDLE    = 2'd0,
        NS_HELD    = 2'd1,
        NS_PRESENT = 2'd2
    } nmi_state_e;
endpackage

// File: rtl/nmi_sync.sv
module nmi_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= din;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[STAGES-2:0], din};
            end
        end
    endgenerate

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/nmi_edge_blank.sv
module nmi_edge_blank #(
    parameter int BLANK_CYC = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level_in,
    input  logic pol_rise,
    input  logic restart,
    output logic edge_hit
);
    localparam int CW = $clog2(BLANK_CYC + 1);

    logic          level_prev;
    logic [CW-1:0] blank_cnt;
    logic          raw_edge;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) level_prev <= 1'b0;
        else        level_prev <= level_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 blank_cnt <= '0;
        else if (restart)           blank_cnt <= CW'(BLANK_CYC);
        else if (blank_cnt != '0)   blank_cnt <= blank_cnt - 1'b1;
    end

    always_comb begin
        if (pol_rise) raw_edge = level_in & ~level_prev;
        else          raw_edge = ~level_in & level_prev;
    end

    assign edge_hit = raw_edge && (blank_cnt == '0);
endmodule

// File: rtl/nmi_accept_fsm.sv
module nmi_accept_fsm
    import nmi_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic edge_hit,
    input  logic accept_ok,
    input  logic ack,
    input  logic mload_en,
    output logic req,
    output logic mask_load
);
    nmi_state_e state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            NS_IDLE: begin
                if (edge_hit) state_nx = accept_ok ? NS_PRESENT : NS_HELD;
            end
            NS_HELD: begin
                if (accept_ok) state_nx = NS_PRESENT;
            end
            NS_PRESENT: begin
                if (edge_hit)       state_nx = accept_ok ? NS_PRESENT : NS_HELD;
                else if (ack)       state_nx = NS_IDLE;
                else if (!accept_ok) state_nx = NS_HELD;
            end
            default: state_nx = NS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= NS_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        req       = (state == NS_PRESENT);
        mask_load = (state == NS_PRESENT) && ack && mload_en;
    end
endmodule

// File: rtl/nmi_accept_unit.sv
module nmi_accept_unit
    import nmi_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int BLANK_CYC   = 6
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   nmi_pin,
    input  logic                   cfg_we,
    input  logic [CFG_W-1:0]       cfg_wdata,
    input  logic                   cpu_block,
    input  logic                   cpu_sleep,
    input  logic                   nmi_ack,
    output logic                   nmi_req,
    output logic [NMI_LEVEL_W-1:0] nmi_level,
    output logic                   mask_we,
    output logic [MASK_W-1:0]      mask_val
);
    logic cfg_rise, cfg_force, cfg_mload;
    logic pin_sync, pol_change, edge_hit, accept_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_rise  <= 1'b1;
            cfg_force <= 1'b0;
            cfg_mload <= 1'b0;
        end else if (cfg_we) begin
            cfg_rise  <= cfg_wdata[CFG_RISE];
            cfg_force <= cfg_wdata[CFG_FORCE];
            cfg_mload <= cfg_wdata[CFG_MLOAD];
        end
    end

    assign pol_change = cfg_we && (cfg_wdata[CFG_RISE] != cfg_rise);
    assign accept_ok  = !cpu_block || cpu_sleep || cfg_force;

    nmi_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(nmi_pin), .dout(pin_sync)
    );

    nmi_edge_blank #(.BLANK_CYC(BLANK_CYC)) u_edge (
        .clk(clk), .rst_n(rst_n), .level_in(pin_sync), .pol_rise(cfg_rise),
        .restart(pol_change), .edge_hit(edge_hit)
    );

    nmi_accept_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .edge_hit(edge_hit), .accept_ok(accept_ok),
        .ack(nmi_ack), .mload_en(cfg_mload), .req(nmi_req), .mask_load(mask_we)
    );

    assign nmi_level = NMI_LEVEL_W'(NMI_LEVEL);
    assign mask_val  = MASK_W'(MASK_LOAD);
endmodule

// File: rtl/nmi_accept_chk.sv
module nmi_accept_chk #(
    parameter int BLANK_CYC = 6
) (
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_rise,
    input logic       cfg_force,
    input logic       edge_hit,
    input logic       cpu_block,
    input logic       cpu_sleep,
    input logic       nmi_ack,
    input logic       nmi_req,
    input logic [4:0] nmi_level,
    input logic       mask_we,
    input logic [3:0] mask_val
);
    localparam int CW = $clog2(BLANK_CYC + 1);
    logic          rise_seen;
    logic [CW-1:0] win_cnt;
    logic          flipped;

    assign flipped = (cfg_rise != rise_seen);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rise_seen <= 1'b1;
            win_cnt   <= '0;
        end else begin
            rise_seen <= cfg_rise;
            if (flipped)            win_cnt <= CW'(BLANK_CYC - 1);
            else if (win_cnt != '0) win_cnt <= win_cnt - 1'b1;
        end
    end

    always_comb begin
        if (rst_n) p_level_r1: assert (nmi_level == 5'd16);
    end

    p_blank_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (flipped || win_cnt != '0) |-> !edge_hit);

    p_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nmi_req) |-> $past(!cpu_block || cpu_sleep || cfg_force));

    p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_req && nmi_ack && !edge_hit) |=> !nmi_req);

    p_mask_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mask_we |-> (nmi_req && nmi_ack && mask_val == 4'd15));
endmodule

bind nmi_accept_unit nmi_accept_chk #(.BLANK_CYC(BLANK_CYC)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_rise(cfg_rise), .cfg_force(cfg_force),
    .edge_hit(edge_hit), .cpu_block(cpu_block), .cpu_sleep(cpu_sleep),
    .nmi_ack(nmi_ack), .nmi_req(nmi_req), .nmi_level(nmi_level),
    .mask_we(mask_we), .mask_val(mask_val)
);

// File: tb/test_nmi_accept_unit.sv
module test_nmi_accept_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       nmi_pin = 1'b0;
    logic       cfg_we = 1'b0;
    logic [2:0] cfg_wdata = 3'b001;
    logic       cpu_block = 1'b0;
    logic       cpu_sleep = 1'b0;
    logic       nmi_ack = 1'b0;
    logic       nmi_req;
    logic [4:0] nmi_level;
    logic       mask_we;
    logic [3:0] mask_val;

    int cyc = 0;
    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    typedef struct {
        int    due;
        int    fld;
        int    exp;
        string rid;
    } item_t;
    item_t sb[$];
    item_t mon_it;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    nmi_accept_unit i_nmi_accept_unit (
        .clk(clk), .rst_n(rst_n), .nmi_pin(nmi_pin), .cfg_we(cfg_we),
        .cfg_wdata(cfg_wdata), .cpu_block(cpu_block), .cpu_sleep(cpu_sleep),
        .nmi_ack(nmi_ack), .nmi_req(nmi_req), .nmi_level(nmi_level),
        .mask_we(mask_we), .mask_val(mask_val)
    );

    function automatic int observe(input int fld);
        case (fld)
            0: return int'(nmi_req);
            1: return int'(mask_we);
            2: return int'(mask_val);
            default: return int'(nmi_level);
        endcase
    endfunction

    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].due <= cyc) begin
            mon_it = sb.pop_front();
            checks++;
            if (observe(mon_it.fld) != mon_it.exp) begin
                failures++;
                $display("FAIL %s field=%0d cycle=%0d actual=%0d expected=%0d",
                         mon_it.rid, mon_it.fld, cyc, observe(mon_it.fld), mon_it.exp);
            end
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic expect_at(input int dly, input int fld, input int val, input string rid);
        item_t it;
        it.due = cyc + dly; it.fld = fld; it.exp = val; it.rid = rid;
        sb.push_back(it);
    endtask

    task automatic write_cfg(input logic [2:0] v);
        cfg_we = 1'b1; cfg_wdata = v;
        step(1);
        cfg_we = 1'b0;
    endtask

    task automatic do_ack(input int mexp, input string rid);
        nmi_ack = 1'b1;
        expect_at(0, 1, mexp, rid);
        if (mexp == 1) expect_at(0, 2, 15, rid);
        step(1);
        nmi_ack = 1'b0;
        expect_at(0, 0, 0, rid);
        step(1);
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        // R1 / R2: reset state
        expect_at(0, 0, 0, "R2");
        expect_at(0, 1, 0, "R2");
        expect_at(0, 3, 16, "R1");
        step(2);

        // R3: rising edge with default polarity
        nmi_pin = 1'b1;
        expect_at(2, 0, 0, "R3");
        expect_at(3, 0, 1, "R3");
        step(3);
        do_ack(0, "R10");
        // R11: acknowledge without request
        nmi_ack = 1'b1;
        expect_at(0, 1, 0, "R11");
        step(1);
        nmi_ack = 1'b0;
        expect_at(2, 0, 0, "R11");
        step(3);
        // R3: falling change ignored under rising polarity
        nmi_pin = 1'b0;
        expect_at(4, 0, 0, "R3");
        step(5);

        // R4: falling polarity, mask load on
        write_cfg(3'b100);
        step(10);
        nmi_pin = 1'b1;
        expect_at(4, 0, 0, "R4");
        step(5);
        nmi_pin = 1'b0;
        expect_at(3, 0, 1, "R4");
        step(3);
        do_ack(1, "R10");

        // R5: change at N+4 dropped
        write_cfg(3'b101);
        step(3);
        nmi_pin = 1'b1;
        expect_at(3, 0, 0, "R5");
        expect_at(8, 0, 0, "R5");
        step(9);
        nmi_pin = 1'b0;
        step(5);
        // R6: same polarity write, no blanking
        write_cfg(3'b101);
        nmi_pin = 1'b1;
        expect_at(3, 0, 1, "R6");
        step(3);
        do_ack(1, "R6");
        // R5: change at N+5 detected
        write_cfg(3'b100);
        step(4);
        nmi_pin = 1'b0;
        expect_at(3, 0, 1, "R5");
        step(3);
        do_ack(1, "R5");

        // R7: block holds the request
        write_cfg(3'b101);
        step(10);
        cpu_block = 1'b1;
        nmi_pin = 1'b1;
        expect_at(3, 0, 0, "R7");
        expect_at(6, 0, 0, "R7");
        step(6);
        cpu_block = 1'b0;
        expect_at(1, 0, 1, "R7");
        step(1);
        do_ack(1, "R7");

        // R8: sleep overrides block
        nmi_pin = 1'b0;
        step(4);
        cpu_block = 1'b1;
        cpu_sleep = 1'b1;
        nmi_pin = 1'b1;
        expect_at(3, 0, 1, "R8");
        step(3);
        do_ack(1, "R8");
        // R8: sleep with block clear
        cpu_block = 1'b0;
        nmi_pin = 1'b0;
        step(4);
        nmi_pin = 1'b1;
        expect_at(3, 0, 1, "R8");
        step(3);
        do_ack(1, "R8");
        cpu_sleep = 1'b0;

        // R9: force accept with block set, mask load off
        write_cfg(3'b011);
        cpu_block = 1'b1;
        nmi_pin = 1'b0;
        step(4);
        nmi_pin = 1'b1;
        expect_at(3, 0, 1, "R9");
        step(3);
        do_ack(0, "R9");
        cpu_block = 1'b0;

        step(5);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule